// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical frame number after a miss in the translation buffer. It walks a two-level page table in main memory. A request brings a 20-bit virtual page number and the frame that holds the root (outer) table. The walker reads one outer entry and then one inner entry over a simple word-read memory port. When both entries are marked valid, it returns the frame number so that the translation buffer can store the page/frame pair.

The page number is split into two 10-bit indices, the upper one for the outer table and the lower one for the inner table. Pages are 4 KB and entries are 32 bits wide, so one table page holds 1024 entries. The byte address of an entry is the table's frame number shifted left by 12, plus the index shifted left by 2. In every entry, bit 0 is the valid flag and bits 31:12 carry a frame number. If an entry at either level has its valid flag clear, the walk stops and reports a fault in place of a result. The walker takes one request at a time. It drives the memory request and address, holds both until the memory grants, and then waits any number of cycles for the read data.

Top module: `two_level_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, reqReady is 1, and memReq, done and fault are 0.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both 1. In the next cycle, memReq is 1 and memAddr = (reqRoot << 12) + (upper 10 bits of reqVpn << 2). reqReady stays 0 until the walk ends, and reqValid, reqVpn and reqRoot have no effect while it is 0.
- R3: While memReq is 1 and memGnt is 0, memReq stays 1 and memAddr does not change. memReq is 0 in the cycle after a grant.
- R4: In the cycle after a read response (memRvalid) to the outer read whose bit 0 is 1, memReq is 1 and memAddr = (memRdata[31:12] << 12) + (lower 10 bits of reqVpn << 2).
- R5: A successful walk issues exactly two granted reads. No read is requested while the walker waits for a response.
- R6: In the cycle after a response to the inner read whose bit 0 is 1, done is 1 for exactly one cycle and frameOut equals memRdata[31:12] of that response. done and fault are never 1 together.
- R7: If the response to the outer read has bit 0 = 0, fault is 1 for one cycle in the next cycle with faultLevel = 0, and no inner read is issued.
- R8: If the response to the inner read has bit 0 = 0, fault is 1 for one cycle in the next cycle with faultLevel = 1.
- R9: In the cycle after a done or fault pulse, reqReady is 1. memRvalid has no effect while no response is awaited.
- R10: The result does not depend on grant or response latency, including a grant in the same cycle as the request and a response in the cycle right after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A walk request is offered |
| reqVpn | input | 20 | Virtual page number to resolve |
| reqRoot | input | 20 | Frame that holds the outer table |
| reqReady | output | 1 | Walker is idle and takes a request |
| done | output | 1 | One-cycle pulse: translation is complete |
| fault | output | 1 | One-cycle pulse: an invalid entry was found |
| faultLevel | output | 1 | Level of the invalid entry, 0 outer and 1 inner; valid with fault |
| frameOut | output | 20 | Resolved frame number; valid with done |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Byte address of the entry to read |
| memGnt | input | 1 | Memory accepts the request |
| memRvalid | input | 1 | Read data is present |
| memRdata | input | 32 | Entry word that was read |

## Verification
The bench builds the walker with its default widths: 20-bit frames and 10-bit indices, which fill the 32-bit entry and address exactly. Under these values, the extreme indices 0 and 1023 and the all-ones root frame use every address bit, so a misplaced shift or a wrong field slice shows up as a wrong address. Grant and response delays are set for each walk, from zero up to several cycles. This reaches the cases where the grant comes in the request cycle, where the address must stay stable through a long stall, and where stray read data arrives while the walker is idle.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [2:0] {
    IDLE       = 3'd0,
    READ_OUTER = 3'd1,
    WAIT_OUTER = 3'd2,
    READ_INNER = 3'd3,
    WAIT_INNER = 3'd4,
    DONE       = 3'd5
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadInnerBase;
    logic loadFrame;
    logic selInner;
  } walkStrobe_t;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memGnt,
  input  logic        memRvalid,
  input  logic        entryValid,
  output logic        reqReady,
  output logic        memReq,
  output logic        done,
  output logic        fault,
  output logic        faultLevel,
  output walkStrobe_t strobe
);

  walkState_e state, nextState;
  logic faultQ, faultLevelQ;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          nextState      = READ_OUTER;
        end
      end
      READ_OUTER: begin
        if (memGnt) nextState = WAIT_OUTER;
      end
      WAIT_OUTER: begin
        if (memRvalid) begin
          if (entryValid) begin
            strobe.loadInnerBase = 1'b1;
            nextState            = READ_INNER;
          end else begin
            nextState = DONE;
          end
        end
      end
      READ_INNER: begin
        strobe.selInner = 1'b1;
        if (memGnt) nextState = WAIT_INNER;
      end
      WAIT_INNER: begin
        strobe.selInner = 1'b1;
        if (memRvalid) begin
          strobe.loadFrame = entryValid;
          nextState        = DONE;
        end
      end
      DONE:    nextState = IDLE;
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= IDLE;
      faultQ      <= 1'b0;
      faultLevelQ <= 1'b0;
    end else begin
      state <= nextState;
      if (state == IDLE && reqValid) begin
        faultQ      <= 1'b0;
        faultLevelQ <= 1'b0;
      end else if (state == WAIT_OUTER && memRvalid && !entryValid) begin
        faultQ      <= 1'b1;
        faultLevelQ <= 1'b0;
      end else if (state == WAIT_INNER && memRvalid && !entryValid) begin
        faultQ      <= 1'b1;
        faultLevelQ <= 1'b1;
      end
    end
  end

  assign reqReady   = (state == IDLE);
  assign memReq     = (state == READ_OUTER) || (state == READ_INNER);
  assign done       = (state == DONE) && !faultQ;
  assign fault      = (state == DONE) && faultQ;
  assign faultLevel = faultLevelQ;

endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int FRAME_W = 20,
  parameter int IDX_W   = 10,
  parameter int DATA_W  = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  walkStrobe_t            strobe,
  input  logic [2*IDX_W-1:0]     reqVpn,
  input  logic [FRAME_W-1:0]     reqRoot,
  input  logic [DATA_W-1:0]      memRdata,
  output logic                   entryValid,
  output logic [FRAME_W+IDX_W+1:0] memAddr,
  output logic [FRAME_W-1:0]     frameOut
);

  localparam int ENTRY_SHIFT = 2;
  localparam int OFF_W       = IDX_W + ENTRY_SHIFT;
  localparam int LEVELS      = 2;

  logic [2*IDX_W-1:0] vpnQ;
  logic [FRAME_W-1:0] rootQ, innerBaseQ, frameQ;
  logic [FRAME_W-1:0] entryFrame;
  logic [IDX_W-1:0]   levelIdx [LEVELS];

  // level 0 = outer (upper bits), level 1 = inner (lower bits)
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign levelIdx[g] = vpnQ[(LEVELS-g)*IDX_W-1 -: IDX_W];
  end

  assign entryFrame = memRdata[OFF_W +: FRAME_W];
  assign entryValid = memRdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vpnQ       <= '0;
      rootQ      <= '0;
      innerBaseQ <= '0;
      frameQ     <= '0;
    end else begin
      if (strobe.loadReq) begin
        vpnQ  <= reqVpn;
        rootQ <= reqRoot;
      end
      if (strobe.loadInnerBase) innerBaseQ <= entryFrame;
      if (strobe.loadFrame)     frameQ     <= entryFrame;
    end
  end

  always_comb begin
    if (strobe.selInner)
      memAddr = {innerBaseQ, levelIdx[1], {ENTRY_SHIFT{1'b0}}};
    else
      memAddr = {rootQ, levelIdx[0], {ENTRY_SHIFT{1'b0}}};
  end

  assign frameOut = frameQ;

endmodule

// File: rtl/two_level_walker.sv
module two_level_walker
  import walk_pkg::*;
#(
  parameter int FRAME_W = 20,
  parameter int IDX_W   = 10,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2*IDX_W-1:0] reqVpn,
  input  logic [FRAME_W-1:0] reqRoot,
  output logic               reqReady,
  output logic               done,
  output logic               fault,
  output logic               faultLevel,
  output logic [FRAME_W-1:0] frameOut,
  output logic               memReq,
  output logic [FRAME_W+IDX_W+1:0] memAddr,
  input  logic               memGnt,
  input  logic               memRvalid,
  input  logic [DATA_W-1:0]  memRdata
);

  localparam int ADDR_W = FRAME_W + IDX_W + 2;

  walkStrobe_t strobe;
  logic        entryValid;

  walk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memGnt     (memGnt),
    .memRvalid  (memRvalid),
    .entryValid (entryValid),
    .reqReady   (reqReady),
    .memReq     (memReq),
    .done       (done),
    .fault      (fault),
    .faultLevel (faultLevel),
    .strobe     (strobe)
  );

  walk_dpath #(
    .FRAME_W (FRAME_W),
    .IDX_W   (IDX_W),
    .DATA_W  (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVpn     (reqVpn),
    .reqRoot    (reqRoot),
    .memRdata   (memRdata),
    .entryValid (entryValid),
    .memAddr    (memAddr),
    .frameOut   (frameOut)
  );

endmodule

// File: rtl/walk_chk.sv
module walk_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memGnt,
  input logic              done,
  input logic              fault
);

  // R2
  accept_starts_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> (memReq && !reqReady));

  // R2
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq);

  // R3
  hold_until_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr)));

  // R3
  drop_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt) |=> !memReq);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fault));

  // R9
  ready_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || fault) |=> reqReady);

endmodule

bind two_level_walker walk_chk #(.ADDR_W(ADDR_W)) u_walk_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .memReq   (memReq),
  .memAddr  (memAddr),
  .memGnt   (memGnt),
  .done     (done),
  .fault    (fault)
);

// File: tb/test_two_level_walker.sv
module test_two_level_walker;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [19:0] reqVpn = '0;
  logic [19:0] reqRoot = '0;
  logic        reqReady, done, fault, faultLevel, memReq;
  logic [19:0] frameOut;
  logic [31:0] memAddr;
  logic        memGnt = 1'b0;
  logic        memRvalid = 1'b0;
  logic [31:0] memRdata = '0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  two_level_walker i_two_level_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVpn(reqVpn),
    .reqRoot(reqRoot), .reqReady(reqReady), .done(done), .fault(fault),
    .faultLevel(faultLevel), .frameOut(frameOut), .memReq(memReq),
    .memAddr(memAddr), .memGnt(memGnt), .memRvalid(memRvalid),
    .memRdata(memRdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // ---------------- memory model ----------------
  logic [31:0] mem [int unsigned];
  int gntDelay = 0;
  int rspDelay = 0;
  int gntCnt = 0;
  int rspCnt = 0;
  bit pend = 0;
  int unsigned pendAddr = 0;
  int readsSeen = 0;
  bit stray = 0;

  function automatic logic [31:0] entry(input int unsigned frame, input bit valid);
    return (frame << 12) | (valid ? 32'd1 : 32'd0);
  endfunction

  always @(negedge clk) begin
    memGnt    = 1'b0;
    memRvalid = 1'b0;
    if (pend) begin
      if (rspCnt == 0) begin
        memRvalid = 1'b1;
        memRdata  = mem.exists(pendAddr) ? mem[pendAddr] : 32'h0;
        pend      = 0;
      end else rspCnt--;
    end else if (stray) begin
      memRvalid = 1'b1;
      memRdata  = 32'hFFFF_FFFF;
    end
    if (memReq && rstN) begin
      if (gntCnt >= gntDelay) begin
        memGnt   = 1'b1;
        pendAddr = memAddr;
        rspCnt   = rspDelay;
        pend     = 1;
        gntCnt   = 0;
        readsSeen++;
      end else gntCnt++;
    end
  end

  // ---------------- behavioural reference ----------------
  int          ph = 0;
  int unsigned mv = 0, mr = 0, mib = 0, mfr = 0;
  bit          mflt = 0, mlvl = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      ph = 0; mflt = 0; mlvl = 0; mfr = 0;
    end else begin
      case (ph)
        0: if (reqValid) begin mv = reqVpn; mr = reqRoot; ph = 1; end
        1: if (memGnt) ph = 2;
        2: if (memRvalid) begin
             if (memRdata[0]) begin mib = memRdata >> 12; ph = 3; end
             else begin mflt = 1; mlvl = 0; ph = 5; end
           end
        3: if (memGnt) ph = 4;
        4: if (memRvalid) begin
             if (memRdata[0]) begin mfr = memRdata >> 12; mflt = 0; end
             else begin mflt = 1; mlvl = 1; end
             ph = 5;
           end
        default: begin ph = 0; mflt = 0; end
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    int unsigned expAddr;
    if (rstN) begin
      chk(reqReady == (ph == 0), "R2 reqReady", reqReady, ph == 0);
      chk(memReq == (ph == 1 || ph == 3), "R5 memReq", memReq, ph == 1 || ph == 3);
      if (ph == 1) begin
        expAddr = (mr << 12) + (((mv >> 10) & 32'h3FF) << 2);
        chk(memAddr == expAddr, "R2 outer address", memAddr, expAddr);
      end
      if (ph == 3) begin
        expAddr = (mib << 12) + ((mv & 32'h3FF) << 2);
        chk(memAddr == expAddr, "R4 inner address", memAddr, expAddr);
      end
      chk(done == (ph == 5 && !mflt), "R6 done", done, ph == 5 && !mflt);
      chk(fault == (ph == 5 && mflt), "R7 fault", fault, ph == 5 && mflt);
      if (ph == 5 && !mflt) chk(frameOut == mfr, "R6 frameOut", frameOut, mfr);
      if (ph == 5 && mflt) chk(faultLevel == mlvl, "R8 faultLevel", faultLevel, mlvl);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      finishRun();
    end
  end

  // ---------------- scenario tasks ----------------
  task automatic walk(input logic [19:0] vpn, input logic [19:0] root,
                      input bit hold, input bit expF, input bit expL,
                      input logic [19:0] expFr, input int expReads,
                      input string tag);
    int n;
    while (!reqReady) @(negedge clk);
    readsSeen = 0;
    reqValid = 1'b1; reqVpn = vpn; reqRoot = root;
    @(negedge clk);
    if (hold) begin reqVpn = ~vpn; reqRoot = ~root; end
    else reqValid = 1'b0;
    n = 0;
    while (!(done || fault) && n < 200) begin @(negedge clk); n++; end
    reqValid = 1'b0;
    chk(fault == expF, {tag, " fault"}, fault, expF);
    chk(done == !expF, {tag, " done"}, done, !expF);
    if (expF) chk(faultLevel == expL, {tag, " level"}, faultLevel, expL);
    else      chk(frameOut == expFr, {tag, " frame"}, frameOut, expFr);
    chk(readsSeen == expReads, {tag, " reads"}, readsSeen, expReads);
    @(negedge clk);
    chk(reqReady == 1'b1, "R9 ready after end", reqReady, 1);
  endtask

  function automatic int unsigned eaddr(input int unsigned frame, input int unsigned idx);
    return (frame << 12) + (idx << 2);
  endfunction

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1 reqReady", reqReady, 1);
    chk(memReq == 1'b0, "R1 memReq", memReq, 0);
    chk(done == 1'b0 && fault == 1'b0, "R1 done/fault", {done, fault}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && !memReq, "R1 first cycle", {reqReady, memReq}, 2);

    // table contents
    mem[eaddr(20'h12345, 3)]    = entry(20'hABCDE, 1);
    mem[eaddr(20'hABCDE, 7)]    = entry(20'h55555, 1);
    mem[eaddr(20'hFFFFF, 1023)] = entry(20'h80001, 1);
    mem[eaddr(20'h80001, 1023)] = entry(20'hFFFFF, 1);
    mem[eaddr(20'h00000, 0)]    = entry(20'h00010, 1);
    mem[eaddr(20'h00010, 0)]    = entry(20'h00000, 1);
    mem[eaddr(20'h00200, 5)]    = entry(20'h0F0F0, 0);
    mem[eaddr(20'h00200, 6)]    = entry(20'h00300, 1);
    mem[eaddr(20'h00300, 9)]    = entry(20'h12121, 0);

    // R6: basic walk, zero latency (R10)
    gntDelay = 0; rspDelay = 0;
    walk({10'd3, 10'd7}, 20'h12345, 0, 0, 0, 20'h55555, 2, "R6 basic");
    // R3 R10: long stalls
    gntDelay = 3; rspDelay = 4;
    walk({10'd3, 10'd7}, 20'h12345, 0, 0, 0, 20'h55555, 2, "R10 slow");
    // R4: extreme indices and root
    gntDelay = 1; rspDelay = 0;
    walk({10'd1023, 10'd1023}, 20'hFFFFF, 0, 0, 0, 20'hFFFFF, 2, "R4 max");
    gntDelay = 0; rspDelay = 2;
    walk(20'd0, 20'h00000, 0, 0, 0, 20'h00000, 2, "R5 zero");
    // R7: outer entry invalid
    walk({10'd5, 10'd1}, 20'h00200, 0, 1, 0, 20'h0, 1, "R7 outer");
    // R8: inner entry invalid
    gntDelay = 2; rspDelay = 1;
    walk({10'd6, 10'd9}, 20'h00200, 0, 1, 1, 20'h0, 2, "R8 inner");
    // R2: request inputs change and stay valid during walk
    walk({10'd3, 10'd7}, 20'h12345, 1, 0, 0, 20'h55555, 2, "R2 busy ignore");
    // R9: stray read data while idle
    stray = 1;
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1 && !done && !fault && !memReq, "R9 stray rvalid",
        {reqReady, done, fault, memReq}, 4'b1000);
    stray = 0;
    @(negedge clk);
    // R10: back-to-back after stray, fast again
    gntDelay = 0; rspDelay = 0;
    walk({10'd1023, 10'd1023}, 20'hFFFFF, 0, 0, 0, 20'hFFFFF, 2, "R10 again");
    walk({10'd5, 10'd1}, 20'h00200, 0, 1, 0, 20'h0, 1, "R7 again");
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule